// File: doc/BRIEF.md
# Streaming Frame Match Engine

This block classifies an Ethernet frame while the frame streams in, one 16-bit word per valid cycle. A small program memory holds compare instructions. Each instruction masks one word of the frame, compares it with a constant and merges the one-bit outcome into one of 32 single-bit result flags. Instruction k runs in the same cycle as frame word k, so the program advances in lockstep with the data and never stalls the stream.

Software loads the program through a write port. Before an instruction is stored, the loader checks it. An instruction whose mask is not nibble-aligned is refused. So is an instruction that tries to read a word that has not yet arrived when it runs. A refused write leaves the slot unchanged and raises an error pulse.

A frame starts with a start-of-frame word. The engine stops when the frame ends or when the program marks an instruction as its last, whichever comes first. At that point it pulses a done strobe, and the result flags stay on the result output until the next frame starts. Frame delineation, checksum handling and any action taken on the result belong to neighbouring blocks.

Top module: `frame_match_engine`

## Requirements
- R1: After synchronous reset, `res_vec` is all zeros, and `res_valid` and `prog_err` are low.
- R2: An instruction word is packed as value [15:0], mask [31:16], word offset [37:32], operation [38] (0 = MOV, 1 = AND), destination flag [43:39] and last-instruction flag [44]. MOV writes the compare outcome into the destination flag. The outcome is 1 when (word & mask) equals (value & mask).
- R3: AND writes the destination flag's previous value ANDed with the compare outcome, so two chained instructions match a 32-bit constant spread over two words.
- R4: A mask is compared nibble by nibble, and nibbles whose mask is zero are ignored. A write whose mask has any nibble other than 0x0 or 0xF is refused. `prog_err` goes high in the cycle after such a write and the program slot keeps its old content.
- R5: A write whose word offset is greater than its program address is refused in the same way, with `prog_err` and the slot left unchanged.
- R6: Frame word k runs the instruction at address k. An instruction whose offset equals its own address compares the word arriving in that same cycle. A smaller offset compares a word captured earlier in the same frame.
- R7: A valid word with `in_sof` high restarts execution at address 0 and clears every result flag that its instruction does not write.
- R8: When a valid word carries `in_eof`, `res_valid` pulses for one cycle after that word, and `res_vec` then shows the final flags.
- R9: When an instruction with the last flag set runs before the end of the frame, `res_valid` pulses after that word. Later words of the frame change nothing and produce no second pulse.
- R10: Address 63 is an implicit end of program. A frame longer than 64 words produces exactly one `res_valid`, after word 63.
- R11: Valid words that arrive while the engine is idle and carry no `in_sof` leave `res_vec` unchanged and raise no `res_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_we | input | 1 | Program write strobe |
| prog_addr | input | 6 | Program slot to write |
| prog_wdata | input | 45 | Instruction word, packed as in R2 |
| prog_err | output | 1 | One-cycle pulse when a write was refused |
| in_valid | input | 1 | Frame word valid |
| in_sof | input | 1 | First word of a frame |
| in_eof | input | 1 | Last word of a frame |
| in_data | input | 16 | Frame word |
| res_valid | output | 1 | One-cycle pulse: classification finished |
| res_vec | output | 32 | Result flags |

## Verification
The hardest case to reach from the ports is the interaction between the two ways a run can end. A program can end early through its last flag or through the implicit end at address 63, and the frame can keep streaming words after that, up to and including its end-of-frame word.

The stimulus table contains a frame that keeps going after its last instruction, with a trailing end-of-frame word. A directed test clears the last flag and streams a 70-word frame so that execution runs into the implicit end. In both cases the bench counts the done pulses and records the word at which each one appears.

The refused-write cases are checked the same way. After each rejected write the bench streams a known frame again and confirms that the classification result has not changed.

// File: rtl/fme_pkg.sv
package fme_pkg;

    localparam int WORD_W     = 16;
    localparam int PROG_DEPTH = 64;
    localparam int NUM_FLAGS  = 32;
    localparam int AW         = $clog2(PROG_DEPTH);
    localparam int FW         = $clog2(NUM_FLAGS);
    localparam int NIBBLES    = WORD_W / 4;

    typedef enum logic {
        OP_MOV = 1'b0,
        OP_AND = 1'b1
    } op_e;

    typedef struct packed {
        logic              last;
        logic [FW-1:0]     dest;
        op_e               op;
        logic [AW-1:0]     offset;
        logic [WORD_W-1:0] mask;
        logic [WORD_W-1:0] value;
    } insn_t;

    localparam int INSN_W = $bits(insn_t);

    // every nibble of the mask must be all zeros or all ones
    function automatic logic mask_legal(input logic [WORD_W-1:0] m);
        logic ok;
        ok = 1'b1;
        for (int n = 0; n < NIBBLES; n++) begin
            if (m[n*4 +: 4] != 4'h0 && m[n*4 +: 4] != 4'hF) begin
                ok = 1'b0;
            end
        end
        return ok;
    endfunction

    function automatic logic word_hit(input logic [WORD_W-1:0] w,
                                      input insn_t             i);
        return (w & i.mask) == (i.value & i.mask);
    endfunction

endpackage

// File: rtl/fme_prog_store.sv
module fme_prog_store
    import fme_pkg::*;
#(
    parameter int DEPTH = PROG_DEPTH,
    localparam int A_W  = $clog2(DEPTH)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           we,
    input  logic [A_W-1:0] waddr,
    input  insn_t          wdata,
    input  logic [A_W-1:0] raddr,
    output insn_t          rdata,
    output logic           reject
);

    insn_t mem [DEPTH];
    logic  legal;

    always_comb begin
        legal = mask_legal(wdata.mask) &&
                ({{(32-AW){1'b0}}, wdata.offset} <= {{(32-A_W){1'b0}}, waddr});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reject <= 1'b0;
            for (int k = 0; k < DEPTH; k++) begin
                mem[k] <= '0;
            end
        end else begin
            reject <= we && !legal;
            if (we && legal) begin
                mem[waddr] <= wdata;
            end
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/fme_word_window.sv
module fme_word_window #(
    parameter int DEPTH  = 64,
    parameter int W      = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [W-1:0]     wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [W-1:0]     rd_data
);

    logic [W-1:0] slot [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot[g] <= '0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                slot[g] <= wr_data;
            end
        end
    end

    // the word arriving this cycle is not yet captured: forward it
    always_comb begin
        if (wr_en && rd_idx == wr_idx) begin
            rd_data = wr_data;
        end else begin
            rd_data = slot[rd_idx];
        end
    end

endmodule

// File: rtl/fme_exec.sv
module fme_exec
    import fme_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic                 in_sof,
    input  logic                 in_eof,
    input  insn_t                insn,
    input  logic [WORD_W-1:0]    opnd,
    output logic [AW-1:0]        idx,
    output logic                 fire,
    output logic [NUM_FLAGS-1:0] flags,
    output logic                 done
);

    logic [AW-1:0]        pc;
    logic                 running;
    logic                 hit;
    logic                 stop;
    logic [NUM_FLAGS-1:0] base;
    logic [NUM_FLAGS-1:0] next_flags;

    always_comb begin
        fire = in_valid && (in_sof || running);
        idx  = in_sof ? '0 : pc;
        hit  = word_hit(opnd, insn);
        base = in_sof ? '0 : flags;
        next_flags = base;
        if (insn.op == OP_AND) begin
            next_flags[insn.dest] = base[insn.dest] & hit;
        end else begin
            next_flags[insn.dest] = hit;
        end
        stop = in_eof || insn.last || (idx == AW'(PROG_DEPTH - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc      <= '0;
            running <= 1'b0;
            flags   <= '0;
            done    <= 1'b0;
        end else begin
            done <= fire && stop;
            if (fire) begin
                flags   <= next_flags;
                pc      <= idx + AW'(1);
                running <= !stop;
            end
        end
    end

endmodule

// File: rtl/frame_match_engine.sv
module frame_match_engine
    import fme_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 prog_we,
    input  logic [AW-1:0]        prog_addr,
    input  logic [INSN_W-1:0]    prog_wdata,
    output logic                 prog_err,
    input  logic                 in_valid,
    input  logic                 in_sof,
    input  logic                 in_eof,
    input  logic [WORD_W-1:0]    in_data,
    output logic                 res_valid,
    output logic [NUM_FLAGS-1:0] res_vec
);

    insn_t             cur_insn;
    logic [AW-1:0]     cur_idx;
    logic              cur_fire;
    logic [WORD_W-1:0] operand;

    fme_prog_store #(.DEPTH(PROG_DEPTH)) u_store (
        .clk    (clk),
        .rst    (rst),
        .we     (prog_we),
        .waddr  (prog_addr),
        .wdata  (insn_t'(prog_wdata)),
        .raddr  (cur_idx),
        .rdata  (cur_insn),
        .reject (prog_err)
    );

    fme_word_window #(.DEPTH(PROG_DEPTH), .W(WORD_W)) u_window (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cur_fire),
        .wr_idx  (cur_idx),
        .wr_data (in_data),
        .rd_idx  (cur_insn.offset),
        .rd_data (operand)
    );

    fme_exec u_exec (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_sof   (in_sof),
        .in_eof   (in_eof),
        .insn     (cur_insn),
        .opnd     (operand),
        .idx      (cur_idx),
        .fire     (cur_fire),
        .flags    (res_vec),
        .done     (res_valid)
    );

endmodule

// File: rtl/fme_checker.sv
module fme_checker
    import fme_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 prog_we,
    input logic [AW-1:0]        prog_addr,
    input logic [INSN_W-1:0]    prog_wdata,
    input logic                 prog_err,
    input logic                 in_valid,
    input logic                 in_sof,
    input logic                 in_eof,
    input logic                 res_valid,
    input logic [NUM_FLAGS-1:0] res_vec
);

    // R5: a write reading ahead of its own address is refused
    a_r5_offset_reject: assert property (@(posedge clk) disable iff (rst)
        (prog_we && (prog_wdata[37:32] > prog_addr)) |=> prog_err);

    // R4: an error pulse always follows a write
    a_r4_err_needs_write: assert property (@(posedge clk) disable iff (rst)
        prog_err |-> $past(prog_we));

    // R8: completion only follows an accepted word
    a_r8_done_after_word: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(in_valid));

    // R11: with no word arriving the flags hold
    a_r11_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(res_vec));

    // R7: a start word leaves at most the one written flag set
    a_r7_sof_clears: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_sof) |=> ($countones(res_vec) <= 1));

endmodule

bind frame_match_engine fme_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .prog_we    (prog_we),
    .prog_addr  (prog_addr),
    .prog_wdata (prog_wdata),
    .prog_err   (prog_err),
    .in_valid   (in_valid),
    .in_sof     (in_sof),
    .in_eof     (in_eof),
    .res_valid  (res_valid),
    .res_vec    (res_vec)
);

// File: tb/frame_match_engine_tb.sv
module frame_match_engine_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        prog_we;
    logic [5:0]  prog_addr;
    logic [44:0] prog_wdata;
    logic        prog_err;
    logic        in_valid, in_sof, in_eof;
    logic [15:0] in_data;
    logic        res_valid;
    logic [31:0] res_vec;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    frame_match_engine u_dut (
        .clk(clk), .rst(rst),
        .prog_we(prog_we), .prog_addr(prog_addr), .prog_wdata(prog_wdata),
        .prog_err(prog_err),
        .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
        .res_valid(res_valid), .res_vec(res_vec)
    );

    // frame table: length, words, expected flags, word index of the done pulse
    localparam int NF = 6;
    localparam int    FLEN  [NF] = '{7, 3, 4, 9, 1, 5};
    localparam logic [15:0] FWORD [NF][9] = '{
        '{16'hAAAA, 16'h12FF, 16'hCAFE, 16'hBABE, 16'h0800, 16'h5555, 16'h0006, 16'h0000, 16'h0000},
        '{16'hAAAA, 16'h1300, 16'hCAFE, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000},
        '{16'hAAAA, 16'h12FF, 16'hCAFE, 16'hBABF, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000},
        '{16'h0000, 16'h0000, 16'h0000, 16'hBABE, 16'h0800, 16'h0000, 16'h0006, 16'hFFFF, 16'hFFFF},
        '{16'hAAAA, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000},
        '{16'h55AA, 16'h12AB, 16'hCAFE, 16'hBABE, 16'h0801, 16'h0000, 16'h0000, 16'h0000, 16'h0000}
    };
    localparam logic [31:0] FEXP [NF] = '{32'h3F, 32'h05, 32'h03, 32'h28, 32'h01, 32'h06};
    localparam int    FAT   [NF] = '{6, 2, 3, 6, 0, 4};

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [44:0] mk(input logic last, input logic [4:0] dest,
                                       input logic op, input logic [5:0] off,
                                       input logic [15:0] mask, input logic [15:0] val);
        return {last, dest, op, off, mask, val};
    endfunction

    // drive a write, then sample prog_err one edge later
    task automatic wr(input logic [5:0] a, input logic [44:0] d, output logic err);
        prog_we = 1'b1; prog_addr = a; prog_wdata = d;
        @(negedge clk);
        prog_we = 1'b0;
        err = prog_err;
    endtask

    // sel < 0: long frame of n words, all 16'hAAAA
    task automatic run_frame(input int sel, input int n, input logic sof_on,
                             output logic [31:0] got, output int cnt, output int at);
        cnt = 0; at = -1; got = res_vec;
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b1;
            in_sof   = sof_on && (i == 0);
            in_eof   = (i == n - 1);
            in_data  = (sel < 0) ? 16'hAAAA : FWORD[sel][i];
            @(negedge clk);
            if (res_valid) begin
                cnt++; at = i; got = res_vec;
            end
        end
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        @(negedge clk);
        if (res_valid) cnt++;
    endtask

    task automatic load_base();
        logic e;
        wr(6'd0, mk(0, 5'd0, 1'b0, 6'd0, 16'hFFFF, 16'hAAAA), e);
        wr(6'd1, mk(0, 5'd1, 1'b0, 6'd1, 16'hFF00, 16'h1234), e);
        wr(6'd2, mk(0, 5'd2, 1'b0, 6'd2, 16'hFFFF, 16'hCAFE), e);
        wr(6'd3, mk(0, 5'd2, 1'b1, 6'd3, 16'hFFFF, 16'hBABE), e);
        wr(6'd4, mk(0, 5'd3, 1'b0, 6'd4, 16'hFFFF, 16'h0800), e);
        wr(6'd5, mk(0, 5'd4, 1'b0, 6'd0, 16'h00FF, 16'h00AA), e);
        wr(6'd6, mk(1, 5'd5, 1'b0, 6'd6, 16'hFFFF, 16'h0006), e);
        chk("R2 legal write no error", e, 0);
    endtask

    initial begin
        #600000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] got;
        int          cnt, at;
        logic        e;

        rst = 1'b1; prog_we = 1'b0; prog_addr = '0; prog_wdata = '0;
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 res_vec", res_vec, 0);
        chk("R1 res_valid", res_valid, 0);
        chk("R1 prog_err", prog_err, 0);

        load_base();

        // table walk: R2 R3 R6 R7 R8 R9
        for (int f = 0; f < NF; f++) begin
            run_frame(f, FLEN[f], 1'b1, got, cnt, at);
            chk($sformatf("R2/R3/R6 frame %0d flags", f), got, FEXP[f]);
            chk($sformatf("R8/R9 frame %0d done count", f), cnt, 1);
            chk($sformatf("R8/R9 frame %0d done word", f), at, FAT[f]);
        end

        // R11: idle words without a start word change nothing
        run_frame(0, 4, 1'b0, got, cnt, at);
        chk("R11 no done when idle", cnt, 0);
        chk("R11 flags held", res_vec, FEXP[NF-1]);

        // R4: partial-nibble mask refused, slot 0 unchanged
        wr(6'd0, mk(0, 5'd0, 1'b0, 6'd0, 16'h8001, 16'h0000), e);
        chk("R4 bad mask error", e, 1);
        @(negedge clk);
        chk("R4 error is a pulse", prog_err, 0);
        run_frame(0, FLEN[0], 1'b1, got, cnt, at);
        chk("R4 slot unchanged", got, FEXP[0]);

        // R5: offset beyond own address refused, slot 1 unchanged
        wr(6'd1, mk(0, 5'd1, 1'b0, 6'd5, 16'hFFFF, 16'h0000), e);
        chk("R5 read-ahead error", e, 1);
        run_frame(0, FLEN[0], 1'b1, got, cnt, at);
        chk("R5 slot unchanged", got, FEXP[0]);

        // R10: drop the last flag, 70-word frame ends at address 63
        wr(6'd6, mk(0, 5'd5, 1'b0, 6'd6, 16'hFFFF, 16'h0006), e);
        run_frame(-1, 70, 1'b1, got, cnt, at);
        chk("R10 single done", cnt, 1);
        chk("R10 done at word 63", at, 63);
        chk("R10 flags", got, 32'h11);

        // R1: reset clears flags mid-life
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 flags after reset", res_vec, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule